// File: doc/BRIEF.md
# Receive Descriptor Ring Process Controller

This block sequences the receive half of a descriptor-driven DMA engine. A level-sensitive run control moves it between three process states: Stopped, Running and Suspended. While Running it reads descriptors one at a time from a ring in memory. For each descriptor it looks at a single ownership flag. When the DMA holds the descriptor and a frame is pending, it launches a frame transfer. When the DMA does not hold it, the block parks in Suspended and raises a buffer-unavailable flag.

The memory master, the data path and the rest of the descriptor fields sit outside the block. The block only issues a fetch request with an address and reads back the ownership and end-of-ring flags with the acknowledge. It also emits a transfer-start strobe and accepts a transfer-done strobe.

The descriptor pointer persists across stop and restart. The first start after reset begins at the programmed ring base. Every later start resumes at the descriptor after the last one consumed.

Top module: `rx_ring_ctrl`

## Requirements
- R1: After reset `proc_state` is 2'b00 (Stopped), `fetch_req` and `xfer_start` are low, `rbu_flag` is low and `desc_ptr` is zero.
- R2: With `run_en` high in Stopped, the next cycle shows `proc_state` 2'b01 (Running) and `fetch_req` high. On the first start after reset, `fetch_addr` equals `list_base`.
- R3: While `fetch_req` is high and `fetch_ack` is low, `fetch_req` stays high and `fetch_addr` stays unchanged.
- R4: When an acknowledge arrives with `fetch_own` low and `run_en` high, the next cycle shows `proc_state` 2'b10 (Suspended), `fetch_req` low and `rbu_flag` high.
- R5: After an owned descriptor is fetched, `xfer_start` is high in the same cycle that `frame_pend` and `run_en` are high, and `proc_state` stays 2'b01.
- R6: One cycle after `xfer_done`, the pointer has moved by `DESC_BYTES`, or back to `list_base` if the descriptor carried `fetch_eor`. If `run_en` is still high, a fetch of that new address is issued.
- R7: Clearing `run_en` during a transfer leaves `proc_state` at 2'b01 until `xfer_done`. The next cycle then shows 2'b00.
- R8: Clearing `run_en` while Suspended, or while holding an owned descriptor with no frame, gives `proc_state` 2'b00 on the next cycle.
- R9: A later start resumes at the saved pointer, regardless of the current `list_base`.
- R10: In Suspended, a `poll_dem` or `frame_pend` pulse re-fetches the same descriptor address on the next cycle. An owned result returns the block to Running.
- R11: `rbu_flag` clears one cycle after `rbu_clr` is high. A new set in that same cycle takes priority and leaves it high.
- R12: In Suspended with no poll and no pending frame, the block stays in 2'b10 and issues no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Receive run control level |
| list_base | input | ADDR_W | Ring base address |
| poll_dem | input | 1 | Poll demand pulse |
| frame_pend | input | 1 | A received frame awaits transfer |
| fetch_req | output | 1 | Descriptor read request |
| fetch_addr | output | ADDR_W | Descriptor read address |
| fetch_ack | input | 1 | Descriptor read complete |
| fetch_own | input | 1 | Descriptor is held by the DMA |
| fetch_eor | input | 1 | Descriptor is last in the ring |
| xfer_start | output | 1 | Frame transfer launch |
| xfer_done | input | 1 | Frame transfer finished |
| rbu_flag | output | 1 | Buffer-unavailable status |
| rbu_clr | input | 1 | Write-one-to-clear for `rbu_flag` |
| proc_state | output | 2 | 00 Stopped, 01 Running, 10 Suspended |
| desc_ptr | output | ADDR_W | Current descriptor pointer |

## Verification
State changes, pointer updates and the flag all land one clock after the sampling edge that sees their cause. `fetch_req`, `fetch_addr` and `xfer_start` are decoded from that registered state, and `xfer_start` also follows `frame_pend` in the same cycle. Each check therefore drives its stimulus just after a rising edge and samples results 1 ns after the next edge. The only exception is `xfer_start`, which is read 1 ns after its input is driven. Deferred stop is checked over several edges, to show the state holds until the done strobe and changes exactly one edge after it.

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [ADDR_W-1:0] list_base,
  input  logic              poll_dem,
  input  logic              frame_pend,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ack,
  input  logic              fetch_own,
  input  logic              fetch_eor,
  output logic              xfer_start,
  input  logic              xfer_done,
  output logic              rbu_flag,
  input  logic              rbu_clr,
  output logic [1:0]        proc_state,
  output logic [ADDR_W-1:0] desc_ptr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_HOLD, S_MOVE, S_SUSP} st_t;

  st_t               st;
  logic [ADDR_W-1:0] ptr;
  logic              seeded;
  logic              last_q;
  logic              rbu_set;

  assign rbu_set    = (st == S_FETCH) && fetch_ack && !fetch_own && run_en;
  assign fetch_req  = (st == S_FETCH);
  assign fetch_addr = ptr;
  assign desc_ptr   = ptr;
  assign xfer_start = (st == S_HOLD) && run_en && frame_pend;
  assign proc_state = (st == S_IDLE) ? 2'b00 : (st == S_SUSP) ? 2'b10 : 2'b01;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      seeded <= 1'b0;
      last_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (run_en) begin
            st     <= S_FETCH;
            seeded <= 1'b1;
            if (!seeded) ptr <= list_base;
          end
        S_FETCH:
          if (fetch_ack) begin
            if (!run_en)       st <= S_IDLE;
            else if (fetch_own) begin
              st     <= S_HOLD;
              last_q <= fetch_eor;
            end else           st <= S_SUSP;
          end
        S_HOLD:
          if (!run_en)         st <= S_IDLE;
          else if (frame_pend) st <= S_MOVE;
        S_MOVE:
          if (xfer_done) begin
            ptr <= last_q ? list_base : ptr + STEP;
            st  <= run_en ? S_FETCH : S_IDLE;
          end
        S_SUSP:
          if (!run_en)                     st <= S_IDLE;
          else if (poll_dem || frame_pend) st <= S_FETCH;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rbu_flag <= 1'b0;
    else if (rbu_set) rbu_flag <= 1'b1;
    else if (rbu_clr) rbu_flag <= 1'b0;
  end

  a_r2_start_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 2'b00 && run_en) |=> (proc_state == 2'b01 && fetch_req));

  a_r3_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));

  a_r4_unowned_suspends: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack && !fetch_own && run_en) |=> (proc_state == 2'b10 && rbu_flag));

  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MOVE && xfer_done && !last_q) |=> (desc_ptr == $past(desc_ptr) + STEP));

  a_r7_stop_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MOVE && !xfer_done) |=> (proc_state == 2'b01));

  a_r9_ptr_kept_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 2'b00 && !run_en) |=> $stable(desc_ptr));

  a_r12_no_fetch_suspended: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 2'b10) |-> !fetch_req);
endmodule

// File: tb/tb_rx_ring_ctrl.sv
module tb_rx_ring_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        run_en = 0, poll_dem = 0, frame_pend = 0;
  logic [31:0] list_base = '0;
  logic        fetch_ack = 0, fetch_own = 0, fetch_eor = 0;
  logic        xfer_done = 0, rbu_clr = 0;
  logic        fetch_req, xfer_start, rbu_flag;
  logic [31:0] fetch_addr, desc_ptr;
  logic [1:0]  proc_state;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rx_ring_ctrl #(.ADDR_W(32), .DESC_BYTES(16)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .list_base(list_base),
    .poll_dem(poll_dem), .frame_pend(frame_pend), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_ack(fetch_ack), .fetch_own(fetch_own),
    .fetch_eor(fetch_eor), .xfer_start(xfer_start), .xfer_done(xfer_done),
    .rbu_flag(rbu_flag), .rbu_clr(rbu_clr), .proc_state(proc_state),
    .desc_ptr(desc_ptr));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ack(bit own, bit eor);
    fetch_ack = 1; fetch_own = own; fetch_eor = eor;
    tick();
    fetch_ack = 0; fetch_own = 0; fetch_eor = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; tick(); tick();
    check("R1 state", proc_state, 2'b00);
    check("R1 fetch_req", fetch_req, 0);
    check("R1 xfer_start", xfer_start, 0);
    check("R1 rbu", rbu_flag, 0);
    check("R1 ptr", desc_ptr, 0);
    rst_n = 1;
  endtask

  task automatic t_first_start();
    list_base = 32'h1000; run_en = 1; tick();
    check("R2 state", proc_state, 2'b01);
    check("R2 fetch_req", fetch_req, 1);
    check("R2 addr", fetch_addr, 32'h1000);
  endtask

  task automatic t_hold_fetch();
    tick(); tick();
    check("R3 fetch_req", fetch_req, 1);
    check("R3 addr", fetch_addr, 32'h1000);
  endtask

  task automatic t_suspend();
    ack(0, 0);
    check("R4 state", proc_state, 2'b10);
    check("R4 rbu", rbu_flag, 1);
    check("R4 fetch_req", fetch_req, 0);
  endtask

  task automatic t_susp_idle();
    tick(); tick(); tick();
    check("R12 state", proc_state, 2'b10);
    check("R12 fetch_req", fetch_req, 0);
  endtask

  task automatic t_clear();
    rbu_clr = 1; tick(); rbu_clr = 0;
    check("R11 cleared", rbu_flag, 0);
  endtask

  task automatic t_repoll();
    poll_dem = 1; tick(); poll_dem = 0;
    check("R10 fetch_req", fetch_req, 1);
    check("R10 addr", fetch_addr, 32'h1000);
    check("R10 state", proc_state, 2'b01);
    ack(1, 0);
    check("R10 running", proc_state, 2'b01);
    check("R10 no fetch", fetch_req, 0);
  endtask

  task automatic t_frame_step();
    frame_pend = 1; #1;
    check("R5 xfer_start", xfer_start, 1);
    tick(); frame_pend = 0; #1;
    check("R5 state", proc_state, 2'b01);
    check("R5 strobe ends", xfer_start, 0);
    xfer_done = 1; tick(); xfer_done = 0;
    check("R6 ptr step", desc_ptr, 32'h1010);
    check("R6 fetch_req", fetch_req, 1);
    check("R6 addr", fetch_addr, 32'h1010);
  endtask

  task automatic t_wrap();
    ack(1, 1);
    frame_pend = 1; tick(); frame_pend = 0;
    xfer_done = 1; tick(); xfer_done = 0;
    check("R6 wrap addr", fetch_addr, 32'h1000);
    ack(1, 0);
    frame_pend = 1; tick(); frame_pend = 0;
    xfer_done = 1; tick(); xfer_done = 0;
    check("R6 after wrap", fetch_addr, 32'h1010);
    ack(1, 0);
  endtask

  task automatic t_stop_deferred();
    frame_pend = 1; tick(); frame_pend = 0;
    run_en = 0; tick();
    check("R7 held 1", proc_state, 2'b01);
    tick();
    check("R7 held 2", proc_state, 2'b01);
    xfer_done = 1; tick(); xfer_done = 0;
    check("R7 stopped", proc_state, 2'b00);
    check("R7 fetch_req", fetch_req, 0);
    check("R7 ptr saved", desc_ptr, 32'h1020);
  endtask

  task automatic t_restart();
    list_base = 32'h2000; run_en = 1; tick();
    check("R9 state", proc_state, 2'b01);
    check("R9 resume addr", fetch_addr, 32'h1020);
  endtask

  task automatic t_stops();
    rbu_clr = 1; ack(0, 0); rbu_clr = 0;
    check("R11 set wins", rbu_flag, 1);
    check("R8 suspended", proc_state, 2'b10);
    run_en = 0; tick();
    check("R8 stop from susp", proc_state, 2'b00);
    run_en = 1; tick();
    check("R8 refetch addr", fetch_addr, 32'h1020);
    ack(1, 0);
    run_en = 0; tick();
    check("R8 stop from hold", proc_state, 2'b00);
    check("R8 ptr kept", desc_ptr, 32'h1020);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_start();
    t_hold_fetch();
    t_suspend();
    t_susp_idle();
    t_clear();
    t_repoll();
    t_frame_step();
    t_wrap();
    t_stop_deferred();
    t_restart();
    t_stops();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule